// File: doc/BRIEF.md
# CAN Dual Receive Buffer Manager

This block sits behind a CAN acceptance-filter stage and owns two receive message buffers. Each cycle the filter stage may present one accepted frame (identifier, DLC, up to eight data bytes), the index of the filter that matched, and the buffer it is aimed at. The manager chooses the buffer that stores the frame. It keeps the filter hit in a mode-dependent encoding and raises a full flag and an interrupt flag for that buffer. If no eligible buffer is free, it drops the frame and records an overflow.

Software reads the buffers through a small register window with combinational read data. It frees a buffer by writing zero to its full flag. Buffer 0 can be set to spill into buffer 1 when it is occupied. A stored frame and its filter hit appear together in the cycle after the frame is accepted. The interrupt flag cannot be silenced while its buffer is still full.

Top module: `can_rxbuf_mgr`

## Requirements
- R1: A frame stored into buffer b sets its full flag (control word bit 0) and interrupt flag (bit 1). In the next cycle the identifier (offset 1), DLC (offset 2), data bytes (offset 3 = bytes 0..3, offset 4 = bytes 4..7, little-endian within the 64-bit data) and filter hit (control bits 12:8) read back. The control word of buffer b is at address b*8. `rx_irq[b]` equals the interrupt flag.
- R2: While a buffer is full, no frame is written into it; its contents and filter hit stay unchanged.
- R3: A full flag is cleared only by a control write with bit 0 equal to 0. A write of 1 leaves it unchanged. A store in the same cycle as a clear wins and leaves the flag set. A clear in the same cycle as an arriving frame does not let that frame in.
- R4: If the interrupt flag is cleared (write with bit 1 = 0) while the full flag stays set, it reads 0 for one cycle and is then set again. If it is cleared together with the full flag, it stays 0.
- R5: With double buffering enabled (buffer 0 control bit 3 = 1), a frame aimed at buffer 0 that finds it full is stored into buffer 1 if buffer 1 is free.
- R6: With double buffering disabled, a frame aimed at buffer 0 never enters buffer 1.
- R7: A frame that finds every eligible buffer full is dropped. It sets the sticky overflow flag (bit 2) of the buffer it was aimed at. A write with bit 2 = 0 clears that flag, and a drop in the same cycle wins.
- R8: Buffer 0 control bit 4 is a read-only copy of bit 3. Bits 3 and 4 of buffer 1 read 0.
- R9: In legacy mode (`mode_sel` = 0), buffer 0 records only bit 0 of the filter index, and buffer 1 records its low three bits. The upper hit bits read 0.
- R10: In the enhanced modes (`mode_sel` = 1, 2, 3), the full 5-bit filter index (0 to 15 names filters 0 to 15) is recorded.
- R11: Reset clears both full, interrupt and overflow flags, the double-buffer enable and the stored contents, so every register reads 0.
- R12: A frame aimed at buffer 1 is never written into buffer 0; if buffer 1 is full it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Operating mode: 0 legacy, otherwise enhanced |
| frm_valid | input | 1 | Accepted frame present this cycle |
| frm_dest | input | 1 | Buffer the frame is aimed at |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| frm_filt | input | 5 | Index of the filter that matched |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: bit 3 buffer, bits 2:0 offset |
| reg_wdata | input | 4 | Write data for the writable control bits 3:0 |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| rx_irq | output | 2 | Per-buffer interrupt flags |

## Verification
A wrong routing decision or a stuck full flag shows at the ports in the cycle after the frame arrives. The stored identifier, data or hit of the wrong buffer changes, or an overflow bit rises where a store was due. A bad interrupt flag appears on `rx_irq` within one cycle of the write that clears it, because the one-cycle dip and the re-assertion are compared every clock. Mode-encoding and mirror errors show in the control word read right after a store or an enable write.

// File: rtl/can_rxbuf_pkg.sv
// Shared constants and types for the CAN dual receive buffer manager.
// Assumes two buffers, a 32-bit read window and eight data bytes per frame.
package can_rxbuf_pkg;
    localparam int ID_W       = 29;
    localparam int DLC_W      = 4;
    localparam int DATA_BYTES = 8;
    localparam int DATA_W     = DATA_BYTES * 8;
    localparam int HIT_W      = 5;
    localparam int LEG1_W     = 3;
    localparam int REG_W      = 32;
    localparam int NUM_BUF    = 2;
    localparam int OFF_W      = 3;
    localparam int ADDR_W     = OFF_W + $clog2(NUM_BUF);
    localparam int DATA_WORDS = DATA_W / REG_W;

    // Control word bit positions
    localparam int B_FULL = 0;
    localparam int B_IRQ  = 1;
    localparam int B_OVF  = 2;
    localparam int B_DBL  = 3;
    localparam int B_JTO  = 4;
    localparam int B_HIT  = 8;
    localparam int WR_W   = B_DBL + 1;

    // Register offsets inside one buffer window
    localparam int OFF_CTRL = 0;
    localparam int OFF_ID   = 1;
    localparam int OFF_DLC  = 2;
    localparam int OFF_DATA = 3;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_ENH1   = 2'd1,
        MODE_ENH2   = 2'd2,
        MODE_ENH3   = 2'd3
    } rx_mode_e;
endpackage

// File: rtl/rxbuf_route.sv
// Routing decision for one incoming frame.
// Picks the storing buffer from the aimed buffer, the full flags and the
// double-buffer enable, or flags a drop against the aimed buffer.
// Assumes at most one frame per cycle; purely combinational.
module rxbuf_route
    import can_rxbuf_pkg::*;
(
    input  logic               valid,
    input  logic               dest,
    input  logic               dbl_en,
    input  logic [NUM_BUF-1:0] full,
    output logic [NUM_BUF-1:0] store,
    output logic [NUM_BUF-1:0] drop
);
    // Choose a free buffer, spilling 0 into 1 when enabled, else drop
    always_comb begin
        store = '0;
        drop  = '0;
        if (valid) begin
            if (!dest) begin
                if (!full[0])                  store[0] = 1'b1;
                else if (dbl_en && !full[1])   store[1] = 1'b1;
                else                           drop[0]  = 1'b1;
            end else begin
                if (!full[1])                  store[1] = 1'b1;
                else                           drop[1]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxbuf_slot.sv
// One receive buffer: frame storage, filter hit, full, interrupt and
// overflow flags; buffer 0 also holds the double-buffer enable.
// Assumes the router never stores into a full slot. Control writes clear
// flags by writing 0; a store or a drop in the same cycle wins.
module rxbuf_slot
    import can_rxbuf_pkg::*;
#(
    parameter int BUF_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic             drop,
    input  logic             legacy,
    input  frame_t           frame_in,
    input  logic [HIT_W-1:0] filt,
    input  logic             ctrl_wr,
    input  logic [WR_W-1:0]  ctrl_wdata,
    output frame_t           frame_q,
    output logic [HIT_W-1:0] hit_q,
    output logic             full_q,
    output logic             irq_q,
    output logic             ovf_q,
    output logic             dbl_q
);
    logic [HIT_W-1:0] hit_enc;

    // Mode-dependent filter hit encoding differs per buffer
    generate
        if (BUF_IDX == 0) begin : g_hit0
            assign hit_enc = legacy ? {{(HIT_W-1){1'b0}}, filt[0]} : filt;
        end else begin : g_hit1
            assign hit_enc = legacy ? {{(HIT_W-LEG1_W){1'b0}}, filt[LEG1_W-1:0]} : filt;
        end
    endgenerate

    // Capture frame and hit together, in the same edge that sets full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            hit_q   <= '0;
        end else if (store) begin
            frame_q <= frame_in;
            hit_q   <= hit_enc;
        end
    end

    // Full flag: set by store, cleared only by a software write of 0
    always_ff @(posedge clk) begin
        if (!rst_n)                               full_q <= 1'b0;
        else if (store)                           full_q <= 1'b1;
        else if (ctrl_wr && !ctrl_wdata[B_FULL])  full_q <= 1'b0;
    end

    // Interrupt flag: set by store, re-armed while the buffer stays full
    always_ff @(posedge clk) begin
        if (!rst_n)                               irq_q <= 1'b0;
        else if (store)                           irq_q <= 1'b1;
        else if (ctrl_wr && !ctrl_wdata[B_IRQ])   irq_q <= 1'b0;
        else if (full_q)                          irq_q <= 1'b1;
    end

    // Sticky overflow flag: set by a drop, cleared by a write of 0
    always_ff @(posedge clk) begin
        if (!rst_n)                               ovf_q <= 1'b0;
        else if (drop)                            ovf_q <= 1'b1;
        else if (ctrl_wr && !ctrl_wdata[B_OVF])   ovf_q <= 1'b0;
    end

    // Double-buffer enable exists only in buffer 0
    generate
        if (BUF_IDX == 0) begin : g_dbl
            always_ff @(posedge clk) begin
                if (!rst_n)        dbl_q <= 1'b0;
                else if (ctrl_wr)  dbl_q <= ctrl_wdata[B_DBL];
            end
        end else begin : g_nodbl
            assign dbl_q = 1'b0;
        end
    endgenerate

    // R1
    store_sets_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> (full_q && irq_q));
    // R2
    full_holds_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |=> ($stable(frame_q) && $stable(hit_q)));
    // R3
    full_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_q) |-> $past(ctrl_wr));
    // R4
    irq_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_q) && full_q) |=> irq_q);
    // R7
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_q);
endmodule

// File: rtl/rxbuf_regread.sv
// Combinational read mux for the register window.
// Address bit OFF_W picks the buffer, the low bits the word inside it.
// Assumes unused offsets read as zero.
module rxbuf_regread
    import can_rxbuf_pkg::*;
(
    input  logic [ADDR_W-1:0]             addr,
    input  frame_t [NUM_BUF-1:0]          frames,
    input  logic [NUM_BUF-1:0][HIT_W-1:0] hits,
    input  logic [NUM_BUF-1:0]            full,
    input  logic [NUM_BUF-1:0]            irq,
    input  logic [NUM_BUF-1:0]            ovf,
    input  logic [NUM_BUF-1:0]            dbl,
    output logic [REG_W-1:0]              rdata
);
    logic             sel;
    logic [OFF_W-1:0] off;

    assign sel = addr[ADDR_W-1];
    assign off = addr[OFF_W-1:0];

    // Select the addressed word of the addressed buffer
    always_comb begin
        rdata = '0;
        if (off == OFF_W'(OFF_CTRL)) begin
            rdata[B_FULL]           = full[sel];
            rdata[B_IRQ]            = irq[sel];
            rdata[B_OVF]            = ovf[sel];
            rdata[B_DBL]            = dbl[sel];
            rdata[B_JTO]            = dbl[sel];
            rdata[B_HIT +: HIT_W]   = hits[sel];
        end else if (off == OFF_W'(OFF_ID)) begin
            rdata = REG_W'(frames[sel].id);
        end else if (off == OFF_W'(OFF_DLC)) begin
            rdata = REG_W'(frames[sel].dlc);
        end else begin
            for (int k = 0; k < DATA_WORDS; k++) begin
                if (off == OFF_W'(OFF_DATA + k))
                    rdata = frames[sel].data[k*REG_W +: REG_W];
            end
        end
    end
endmodule

// File: rtl/can_rxbuf_mgr.sv
// Top of the CAN dual receive buffer manager.
// Routes each accepted frame to a buffer, keeps per-buffer flags and
// exposes a register window. Assumes one frame per cycle at most and
// software that writes 1 to control bits it wants to keep.
module can_rxbuf_mgr
    import can_rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              frm_valid,
    input  logic              frm_dest,
    input  logic [ID_W-1:0]   frm_id,
    input  logic [DLC_W-1:0]  frm_dlc,
    input  logic [DATA_W-1:0] frm_data,
    input  logic [HIT_W-1:0]  frm_filt,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WR_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_BUF-1:0] rx_irq
);
    frame_t                        frm_in;
    frame_t [NUM_BUF-1:0]          frame_w;
    logic [NUM_BUF-1:0][HIT_W-1:0] hit_w;
    logic [NUM_BUF-1:0]            full_w, irq_w, ovf_w, dbl_w;
    logic [NUM_BUF-1:0]            store_w, drop_w, ctrl_wr_w;
    logic                          legacy;

    assign frm_in = '{id: frm_id, dlc: frm_dlc, data: frm_data};
    assign legacy = (mode_sel == MODE_LEGACY);

    rxbuf_route u_route (
        .valid  (frm_valid),
        .dest   (frm_dest),
        .dbl_en (dbl_w[0]),
        .full   (full_w),
        .store  (store_w),
        .drop   (drop_w)
    );

    generate
        for (genvar b = 0; b < NUM_BUF; b++) begin : g_slot
            // Decode a control-word write aimed at this buffer
            assign ctrl_wr_w[b] = reg_wr
                && (reg_addr[ADDR_W-1] == b[0])
                && (reg_addr[OFF_W-1:0] == OFF_W'(OFF_CTRL));

            rxbuf_slot #(.BUF_IDX(b)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .store      (store_w[b]),
                .drop       (drop_w[b]),
                .legacy     (legacy),
                .frame_in   (frm_in),
                .filt       (frm_filt),
                .ctrl_wr    (ctrl_wr_w[b]),
                .ctrl_wdata (reg_wdata),
                .frame_q    (frame_w[b]),
                .hit_q      (hit_w[b]),
                .full_q     (full_w[b]),
                .irq_q      (irq_w[b]),
                .ovf_q      (ovf_w[b]),
                .dbl_q      (dbl_w[b])
            );
        end
    endgenerate

    rxbuf_regread u_read (
        .addr   (reg_addr),
        .frames (frame_w),
        .hits   (hit_w),
        .full   (full_w),
        .irq    (irq_w),
        .ovf    (ovf_w),
        .dbl    (dbl_w),
        .rdata  (reg_rdata)
    );

    assign rx_irq = irq_w;

    // R12
    dest1_never_buf0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_dest) |=> $stable(frame_w[0]));
    // R6
    no_spill_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_dest && !dbl_w[0]) |=> $stable(frame_w[1]));
    // R9
    legacy_hit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_dest && !full_w[0] && legacy) |=> (hit_w[0][HIT_W-1:1] == '0));
endmodule

// File: tb/test_can_rxbuf_mgr.sv
`timescale 1ns/1ps
module test_can_rxbuf_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd1;
    logic        frm_valid = 1'b0;
    logic        frm_dest = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic [4:0]  frm_filt = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [3:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  rx_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    bit          m_full [2];
    bit          m_irq  [2];
    bit          m_ovf  [2];
    bit          m_dbl;
    logic [4:0]  m_hit  [2];
    logic [28:0] m_id   [2];
    logic [3:0]  m_dlc  [2];
    logic [63:0] m_data [2];

    always #10 clk = ~clk;

    can_rxbuf_mgr i_can_rxbuf_mgr (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .frm_valid(frm_valid), .frm_dest(frm_dest), .frm_id(frm_id),
        .frm_dlc(frm_dlc), .frm_data(frm_data), .frm_filt(frm_filt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_irq(rx_irq)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Next reference state from the current inputs
    task automatic model_step();
        bit st[2];
        bit dr[2];
        bit cw[2];
        bit old_full[2];
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                m_full[b] = 0; m_irq[b] = 0; m_ovf[b] = 0;
                m_hit[b] = '0; m_id[b] = '0; m_dlc[b] = '0; m_data[b] = '0;
            end
            m_dbl = 0;
            return;
        end
        st[0] = 0; st[1] = 0; dr[0] = 0; dr[1] = 0;
        if (frm_valid) begin
            if (frm_dest == 1'b0) begin
                if (!m_full[0]) st[0] = 1;
                else if (m_dbl && !m_full[1]) st[1] = 1;
                else dr[0] = 1;
            end else begin
                if (!m_full[1]) st[1] = 1; else dr[1] = 1;
            end
        end
        cw[0] = reg_wr && reg_addr == 4'd0;
        cw[1] = reg_wr && reg_addr == 4'd8;
        for (int b = 0; b < 2; b++) old_full[b] = m_full[b];
        for (int b = 0; b < 2; b++) begin
            if (st[b]) begin
                m_id[b] = frm_id; m_dlc[b] = frm_dlc; m_data[b] = frm_data;
                if (mode_sel == 2'd0) m_hit[b] = (b == 0) ? (frm_filt % 2) : (frm_filt % 8);
                else m_hit[b] = frm_filt;
            end
            if (st[b]) m_full[b] = 1;
            else if (cw[b] && !reg_wdata[0]) m_full[b] = 0;
            if (st[b]) m_irq[b] = 1;
            else if (cw[b] && !reg_wdata[1]) m_irq[b] = 0;
            else if (old_full[b]) m_irq[b] = 1;
            if (dr[b]) m_ovf[b] = 1;
            else if (cw[b] && !reg_wdata[2]) m_ovf[b] = 0;
        end
        if (cw[0]) m_dbl = reg_wdata[3];
    endtask

    function automatic logic [31:0] exp_ctrl(input int b);
        logic [31:0] v;
        v = 32'(m_hit[b]) << 8;
        v[0] = m_full[b]; v[1] = m_irq[b]; v[2] = m_ovf[b];
        if (b == 0) begin v[3] = m_dbl; v[4] = m_dbl; end
        return v;
    endfunction

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        reg_addr = 4'(addr);
        #1;
        check(reg_rdata, exp, tag);
    endtask

    // Every clock: advance model, compare interrupt outputs
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        frm_valid = 1'b0;
        check({30'd0, rx_irq}, {30'd0, m_irq[1], m_irq[0]}, "R1/R4 rx_irq");
    endtask

    task automatic check_all(input string tag);
        for (int b = 0; b < 2; b++) begin
            rd(b*8 + 0, exp_ctrl(b), {tag, " ctrl"});
            rd(b*8 + 1, 32'(m_id[b]), {tag, " id"});
            rd(b*8 + 2, 32'(m_dlc[b]), {tag, " dlc"});
            rd(b*8 + 3, m_data[b][31:0], {tag, " data lo"});
            rd(b*8 + 4, m_data[b][63:32], {tag, " data hi"});
            rd(b*8 + 5, 32'd0, {tag, " unused"});
        end
    endtask

    task automatic send(input bit dest, input logic [28:0] id, input logic [3:0] dlc,
                        input logic [63:0] data, input logic [4:0] filt);
        frm_valid = 1'b1; frm_dest = dest; frm_id = id; frm_dlc = dlc;
        frm_data = data; frm_filt = filt;
    endtask

    task automatic wr_ctrl(input int b, input logic [3:0] v);
        reg_wr = 1'b1; reg_addr = 4'(b*8); reg_wdata = v;
    endtask

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R11 reset state
        check_all("R11");
        rd(0, 32'h0, "R11 ctrl0 literal");

        // R1 R10 enhanced store into buffer 0
        mode_sel = 2'd1;
        send(0, 29'h1ABCDEF, 4'd8, 64'h8877665544332211, 5'd13); tick();
        check_all("R1");
        rd(0, 32'h0D03, "R10 ctrl0 hit 13");
        rd(3, 32'h44332211, "R1 data lo");

        // R2 R6 R7 buffer 0 full, no spill
        send(0, 29'h55, 4'd2, 64'hFFFF, 5'd2); tick();
        rd(0, 32'h0D07, "R7 ovf0 set");
        rd(1, 32'h1ABCDEF, "R2 id kept");
        rd(8, 32'h0, "R6 buffer 1 untouched");

        // R4 clear irq only, full kept
        wr_ctrl(0, 4'b0101); tick();
        check({31'd0, rx_irq[0]}, 32'd0, "R4 irq dip");
        tick();
        check({31'd0, rx_irq[0]}, 32'd1, "R4 irq rearmed");

        // R3 R4 clear everything
        wr_ctrl(0, 4'b0000); tick();
        tick();
        rd(0, 32'h0D00, "R3 R4 cleared, hit kept");

        // R8 enable double buffering; writes of 1 leave W0C bits
        wr_ctrl(0, 4'b1111); tick();
        rd(0, 32'h0D18, "R8 mirror");
        rd(8, 32'h0, "R8 buffer 1 bits 3,4");

        // R5 spill into buffer 1
        send(0, 29'h100, 4'd1, 64'hAA, 5'd4); tick();
        rd(0, 32'h041B, "R5 first to buf0");
        send(0, 29'h200, 4'd3, 64'hBBCC, 5'd9); tick();
        rd(8, 32'h0903, "R5 spill to buf1");
        rd(9, 32'h200, "R5 spill id");
        send(0, 29'h300, 4'd3, 64'h1, 5'd1); tick();
        rd(0, 32'h041F, "R7 both full drop");
        // R12 aimed at full buffer 1
        send(1, 29'h400, 4'd3, 64'h2, 5'd3); tick();
        rd(8, 32'h0907, "R12 ovf1");
        rd(1, 32'h100, "R12 buf0 id kept");
        check_all("R5");

        // R9 legacy encodings
        wr_ctrl(0, 4'b1000); tick();
        wr_ctrl(1, 4'b0000); tick();
        mode_sel = 2'd0;
        send(0, 29'h11, 4'd1, 64'h3, 5'd7); tick();
        rd(0, 32'h011B, "R9 buf0 one bit");
        send(1, 29'h22, 4'd1, 64'h4, 5'h1E); tick();
        rd(8, 32'h0603, "R9 buf1 three bits");

        // R3 store wins over same-cycle clear
        wr_ctrl(1, 4'b0000); tick();
        send(1, 29'h33, 4'd5, 64'h5, 5'd5); wr_ctrl(1, 4'b0000); tick();
        rd(8, 32'h0503, "R3 store wins");
        // R3 R7 clear with arrival into full buffer drops
        send(1, 29'h44, 4'd6, 64'h6, 5'd2); wr_ctrl(1, 4'b0000); tick();
        rd(8, 32'h0504, "R3 R7 arrival during clear dropped");
        rd(9, 32'h33, "R2 id kept after drop");
        check_all("R9");

        // Mixed traffic against the reference model
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 3) == 0)
                send($urandom % 2, 29'($urandom), 4'($urandom), {$urandom, $urandom}, 5'($urandom % 16));
            if (($urandom % 4) == 0)
                wr_ctrl($urandom % 2, 4'($urandom));
            if (($urandom % 16) == 0) mode_sel = 2'($urandom);
            tick();
            check_all("R1-mix R2 R3 R5 R7 R10");
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule